// File: doc/BRIEF.md
# Forwarding-Table Lookup Scheduler with Coalesced Updates

This block sits between a forwarding-table client and an external SRAM that has two command ports sharing one data bus direction. Each packet brings one lookup that carries two table addresses: a destination-address key, read on port A, and a source-address key, read on port B. Table updates are queued and are not written one at a time. Once the queue holds a full group, or once a partial group has waited for a set number of cycles, the scheduler stops accepting lookups. It then waits out the read-to-write bus turnaround and writes the whole group back to back, two entries per cycle. The turnaround penalty is therefore paid once for each group and not once for each update.

While updates wait, and until the memory has actually taken their write data, the queue also acts as a small associative cache. A lookup key that matches a queued address is answered from the queue, and no memory read is issued on that port. If several queued entries share the key, the newest one is used. Every response comes out a fixed number of cycles after its lookup was accepted, with the request's tag, so cache answers and memory answers stay in request order.

Top module: `lookup_coalesce_sched`

## Requirements
- R1: After reset, lk_ready and up_ready are 1, rsp_valid is 0, and neither memory port shows a command.
- R2: A lookup accepted in cycle t whose keys are not queued issues a read of the destination key on port A and of the source key on port B in cycle t (cmd_valid=1, cmd_write=0). In cycle t+RD_LAT, rsp_valid=1 with the request's tag, the memory data and both hit flags 0.
- R3: The queue holds at most DEPTH updates. up_ready is 0 whenever the queue is full, and from the cycle a flush is decided until the group's write data has been taken.
- R4: When DEPTH updates are queued, the group is written in arrival order. Each write cycle puts the older entry on port A and the next one on port B.
- R5: A partial group is flushed when its age reaches TIMEOUT. The age is 0 in the first cycle after the first update is queued and rises by one each cycle. The first write follows one cycle after that decision when no turnaround is pending. Before then, up_ready stays 1.
- R6: Every write command comes at least TURN+1 cycles after the most recent read command, so TURN idle cycles separate them.
- R7: lk_ready returns to 1 in the cycle right after the last write command of a group, with no write-to-read gap.
- R8: The write data of a write command issued in cycle w appears on that port's wdata in cycle w+WR_LAT.
- R9: A lookup key that equals a queued update address is answered with the queued data and its hit flag set to 1. No read command is issued on that key's port.
- R10: When several queued updates share a lookup key, the response carries the most recently queued data.
- R11: Queued entries keep answering lookups through cycle w+WR_LAT of the group's last write w. Later lookups read the written data back from memory, with hit 0.
- R12: lk_ready is 0 from the cycle a flush is decided until the group's last write command, and no read shares a cycle with a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle when valid |
| lk_tag | input | TW | Tag returned with the response |
| lk_da_addr | input | AW | Destination-address key |
| lk_sa_addr | input | AW | Source-address key |
| up_valid | input | 1 | Table update valid |
| up_ready | output | 1 | Table update accepted this cycle when valid |
| up_addr | input | AW | Update address |
| up_data | input | DW | Update entry data |
| rsp_valid | output | 1 | Response valid |
| rsp_tag | output | TW | Tag of the answered lookup |
| rsp_da_data | output | DW | Entry for the destination key |
| rsp_sa_data | output | DW | Entry for the source key |
| rsp_da_hit | output | 1 | Destination entry came from the update queue |
| rsp_sa_hit | output | 1 | Source entry came from the update queue |
| mem_a_cmd_valid | output | 1 | Port A command valid |
| mem_a_cmd_write | output | 1 | Port A command is a write |
| mem_a_addr | output | AW | Port A address |
| mem_a_wdata | output | DW | Port A write data, WR_LAT cycles after the command |
| mem_a_rdata | input | DW | Port A read data, RD_LAT cycles after the command |
| mem_b_cmd_valid | output | 1 | Port B command valid |
| mem_b_cmd_write | output | 1 | Port B command is a write |
| mem_b_addr | output | AW | Port B address |
| mem_b_wdata | output | DW | Port B write data, WR_LAT cycles after the command |
| mem_b_rdata | input | DW | Port B read data, RD_LAT cycles after the command |

## Verification
The bench builds the block with AW=8, DW=16 and TW=4, which lets an ordinary array serve as the whole memory model. It keeps DEPTH=4, TURN=4, RD_LAT=5 and WR_LAT=3 at their working values, so group size, turnaround and latencies are exercised exactly as specified. TIMEOUT is lowered to 20. This brings a timeout-driven partial flush into a short run, and still leaves room to show that a partial group is not written early.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WR    = 2'd1,
        ST_DRAIN = 2'd2
    } lkc_state_e;
endpackage

// File: rtl/lkc_delay.sv
module lkc_delay #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [LAT];
    logic [W-1:0] stage_q [LAT];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < LAT; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < LAT; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[LAT-1];
endmodule

// File: rtl/lkc_wr_cache.sv
module lkc_wr_cache #(
    parameter int AW    = 20,
    parameter int DW    = 144,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          clear,
    input  logic [AW-1:0] look_a_addr,
    input  logic [AW-1:0] look_b_addr,
    output logic          hit_a,
    output logic          hit_b,
    output logic [DW-1:0] data_a,
    output logic [DW-1:0] data_b,
    input  logic [IW-1:0] rd0_idx,
    input  logic [IW-1:0] rd1_idx,
    output logic [AW-1:0] rd0_addr,
    output logic [DW-1:0] rd0_data,
    output logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd1_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [CW-1:0]            cnt;
    } cache_t;

    cache_t        cache_d, cache_q;
    logic [IW-1:0] slot;

    always_comb begin
        cache_d = cache_q;
        slot    = cache_q.cnt[IW-1:0];
        if (clear) begin
            cache_d.cnt = '0;
        end else if (push) begin
            cache_d.addr[slot] = push_addr;
            cache_d.data[slot] = push_data;
            cache_d.cnt        = cache_q.cnt + CW'(1);
        end
        // ascending scan: a later (newer) match overrides an older one
        hit_a  = 1'b0;
        hit_b  = 1'b0;
        data_a = '0;
        data_b = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cache_q.cnt && cache_q.addr[i] == look_a_addr) begin
                hit_a  = 1'b1;
                data_a = cache_q.data[i];
            end
            if (CW'(i) < cache_q.cnt && cache_q.addr[i] == look_b_addr) begin
                hit_b  = 1'b1;
                data_b = cache_q.data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cache_q <= '0;
        else        cache_q <= cache_d;
    end

    assign rd0_addr = cache_q.addr[rd0_idx];
    assign rd0_data = cache_q.data[rd0_idx];
    assign rd1_addr = cache_q.addr[rd1_idx];
    assign rd1_data = cache_q.data[rd1_idx];
    assign count    = cache_q.cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cache_q.cnt < CW'(DEPTH)));

    assert_clear_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cache_q.cnt == '0));
endmodule

// File: rtl/lookup_coalesce_sched.sv
module lookup_coalesce_sched
    import lkc_pkg::*;
#(
    parameter int AW      = 20,
    parameter int DW      = 144,
    parameter int TW      = 8,
    parameter int DEPTH   = 4,
    parameter int TURN    = 4,
    parameter int RD_LAT  = 5,
    parameter int WR_LAT  = 3,
    parameter int TIMEOUT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    output logic          lk_ready,
    input  logic [TW-1:0] lk_tag,
    input  logic [AW-1:0] lk_da_addr,
    input  logic [AW-1:0] lk_sa_addr,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_data,
    output logic          rsp_valid,
    output logic [TW-1:0] rsp_tag,
    output logic [DW-1:0] rsp_da_data,
    output logic [DW-1:0] rsp_sa_data,
    output logic          rsp_da_hit,
    output logic          rsp_sa_hit,
    output logic          mem_a_cmd_valid,
    output logic          mem_a_cmd_write,
    output logic [AW-1:0] mem_a_addr,
    output logic [DW-1:0] mem_a_wdata,
    input  logic [DW-1:0] mem_a_rdata,
    output logic          mem_b_cmd_valid,
    output logic          mem_b_cmd_write,
    output logic [AW-1:0] mem_b_addr,
    output logic [DW-1:0] mem_b_wdata,
    input  logic [DW-1:0] mem_b_rdata
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WIW   = CW + 1;
    localparam int AGW   = $clog2(TIMEOUT + 1);
    localparam int SW    = $clog2(TURN + 1);
    localparam int DRW   = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
    localparam int RSP_W = 1 + TW + 2 + 2 * DW;

    typedef struct packed {
        lkc_state_e     st;
        logic [AGW-1:0] age;
        logic [SW-1:0]  since;
        logic [WIW-1:0] widx;
        logic [DRW-1:0] drain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          push, clear, fire, flush_req;
    logic          hit_a, hit_b;
    logic [DW-1:0] cdata_a, cdata_b;
    logic [IW-1:0] rd0_idx, rd1_idx;
    logic [AW-1:0] rd0_addr, rd1_addr;
    logic [DW-1:0] rd0_data, rd1_data;
    logic [CW-1:0] count;
    logic [1:0][DW-1:0] wd_in, wd_out;
    logic [RSP_W-1:0] rsp_din, rsp_dout;
    logic          rp_valid, rp_hit_a, rp_hit_b;
    logic [TW-1:0] rp_tag;
    logic [DW-1:0] rp_da, rp_sa;
    logic          rd_any, wr_any;

    lkc_wr_cache #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(up_addr), .push_data(up_data), .clear(clear),
        .look_a_addr(lk_da_addr), .look_b_addr(lk_sa_addr),
        .hit_a(hit_a), .hit_b(hit_b), .data_a(cdata_a), .data_b(cdata_b),
        .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .count(count)
    );

    always_comb begin
        ctl_d           = ctl_q;
        lk_ready        = 1'b0;
        up_ready        = 1'b0;
        push            = 1'b0;
        clear           = 1'b0;
        mem_a_cmd_valid = 1'b0;
        mem_a_cmd_write = 1'b0;
        mem_a_addr      = lk_da_addr;
        mem_b_cmd_valid = 1'b0;
        mem_b_cmd_write = 1'b0;
        mem_b_addr      = lk_sa_addr;
        wd_in           = '0;
        rd0_idx         = ctl_q.widx[IW-1:0];
        rd1_idx         = rd0_idx + IW'(1);
        flush_req       = (count == CW'(DEPTH)) ||
                          (count != '0 && ctl_q.age >= AGW'(TIMEOUT));

        unique case (ctl_q.st)
            ST_RUN: begin
                lk_ready  = !flush_req;
                up_ready  = !flush_req;
                push      = up_valid && up_ready;
                if (count == '0)                  ctl_d.age = '0;
                else if (ctl_q.age < AGW'(TIMEOUT)) ctl_d.age = ctl_q.age + AGW'(1);
                if (flush_req) begin
                    ctl_d.st   = ST_WR;
                    ctl_d.widx = '0;
                end
            end
            ST_WR: begin
                ctl_d.age = '0;
                if (ctl_q.since >= SW'(TURN)) begin
                    mem_a_cmd_valid = 1'b1;
                    mem_a_cmd_write = 1'b1;
                    mem_a_addr      = rd0_addr;
                    wd_in[0]        = rd0_data;
                    if (ctl_q.widx + WIW'(1) < WIW'(count)) begin
                        mem_b_cmd_valid = 1'b1;
                        mem_b_cmd_write = 1'b1;
                        mem_b_addr      = rd1_addr;
                        wd_in[1]        = rd1_data;
                    end
                    ctl_d.widx = ctl_q.widx + WIW'(2);
                    if (ctl_q.widx + WIW'(2) >= WIW'(count)) begin
                        ctl_d.st    = ST_DRAIN;
                        ctl_d.widx  = '0;
                        ctl_d.drain = DRW'(WR_LAT - 1);
                    end
                end
            end
            ST_DRAIN: begin
                lk_ready = 1'b1;
                if (ctl_q.drain == '0) begin
                    clear     = 1'b1;
                    ctl_d.st  = ST_RUN;
                    ctl_d.age = '0;
                end else begin
                    ctl_d.drain = ctl_q.drain - DRW'(1);
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase

        fire = lk_valid && lk_ready;
        if (fire) begin
            mem_a_cmd_valid = !hit_a;
            mem_b_cmd_valid = !hit_b;
        end

        rd_any = (mem_a_cmd_valid && !mem_a_cmd_write) ||
                 (mem_b_cmd_valid && !mem_b_cmd_write);
        if (rd_any)                        ctl_d.since = '0;
        else if (ctl_q.since < SW'(TURN))  ctl_d.since = ctl_q.since + SW'(1);

        rsp_din = {fire, lk_tag, hit_a, hit_b, cdata_a, cdata_b};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_RUN;
            ctl_q.since <= SW'(TURN);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_wdly
        lkc_delay #(.W(DW), .LAT(WR_LAT)) u_wdly (
            .clk(clk), .rst_n(rst_n), .din(wd_in[p]), .dout(wd_out[p])
        );
    end

    lkc_delay #(.W(RSP_W), .LAT(RD_LAT)) u_rsp_pipe (
        .clk(clk), .rst_n(rst_n), .din(rsp_din), .dout(rsp_dout)
    );

    assign {rp_valid, rp_tag, rp_hit_a, rp_hit_b, rp_da, rp_sa} = rsp_dout;
    assign mem_a_wdata = wd_out[0];
    assign mem_b_wdata = wd_out[1];
    assign rsp_valid   = rp_valid;
    assign rsp_tag     = rp_tag;
    assign rsp_da_hit  = rp_hit_a;
    assign rsp_sa_hit  = rp_hit_b;
    assign rsp_da_data = rp_hit_a ? rp_da : mem_a_rdata;
    assign rsp_sa_data = rp_hit_b ? rp_sa : mem_b_rdata;

    // port-level gap counter kept apart from the scheduler's own timer
    assign wr_any = (mem_a_cmd_valid && mem_a_cmd_write) ||
                    (mem_b_cmd_valid && mem_b_cmd_write);
    logic [SW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= SW'(TURN);
        else if (rd_any) gap_q <= '0;
        else if (gap_q < SW'(TURN)) gap_q <= gap_q + SW'(1);
    end

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |-> (gap_q >= SW'(TURN)));

    assert_no_rw_mix_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |-> (!rd_any && !lk_ready));

    assert_flush_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && count == CW'(DEPTH)) |=> (ctl_q.st == ST_WR));

    assert_up_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_RUN) |-> !(up_valid && up_ready));
endmodule

// File: tb/lookup_coalesce_sched_tb_top.sv
module lookup_coalesce_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 16, TW = 4, DEPTH = 4, TURN = 4;
    localparam int RD_LAT = 5, WR_LAT = 3, TIMEOUT = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic lk_valid = 0, up_valid = 0, lk_ready, up_ready;
    logic [TW-1:0] lk_tag = '0, rsp_tag;
    logic [AW-1:0] lk_da_addr = '0, lk_sa_addr = '0, up_addr = '0;
    logic [DW-1:0] up_data = '0, rsp_da_data, rsp_sa_data;
    logic rsp_valid, rsp_da_hit, rsp_sa_hit;
    logic a_v, a_w, b_v, b_w;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wd, b_wd, a_rd, b_rd;

    lookup_coalesce_sched #(.AW(AW), .DW(DW), .TW(TW), .DEPTH(DEPTH), .TURN(TURN),
        .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_tag(lk_tag),
        .lk_da_addr(lk_da_addr), .lk_sa_addr(lk_sa_addr),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_data(up_data),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_da_data(rsp_da_data),
        .rsp_sa_data(rsp_sa_data), .rsp_da_hit(rsp_da_hit), .rsp_sa_hit(rsp_sa_hit),
        .mem_a_cmd_valid(a_v), .mem_a_cmd_write(a_w), .mem_a_addr(a_addr),
        .mem_a_wdata(a_wd), .mem_a_rdata(a_rd),
        .mem_b_cmd_valid(b_v), .mem_b_cmd_write(b_w), .mem_b_addr(b_addr),
        .mem_b_wdata(b_wd), .mem_b_rdata(b_rd)
    );

    // memory model: read array at the command edge, data RD_LAT cycles later;
    // write data sampled WR_LAT cycles after the write command
    logic [DW-1:0] mem [256];
    logic [RD_LAT-1:0][DW-1:0] rpa, rpb;
    logic [WR_LAT-1:0] wva, wvb;
    logic [WR_LAT-1:0][AW-1:0] waa, wab;

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 7 + 256);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            rpa <= '0; rpb <= '0; wva <= '0; wvb <= '0; waa <= '0; wab <= '0;
        end else begin
            rpa <= {rpa[RD_LAT-2:0], mem[a_addr]};
            rpb <= {rpb[RD_LAT-2:0], mem[b_addr]};
            wva <= {wva[WR_LAT-2:0], a_v && a_w};
            wvb <= {wvb[WR_LAT-2:0], b_v && b_w};
            waa <= {waa[WR_LAT-2:0], a_addr};
            wab <= {wab[WR_LAT-2:0], b_addr};
            if (wva[WR_LAT-1]) mem[waa[WR_LAT-1]] <= a_wd;
            if (wvb[WR_LAT-1]) mem[wab[WR_LAT-1]] <= b_wd;
        end
    end
    assign a_rd = rpa[RD_LAT-1];
    assign b_rd = rpb[RD_LAT-1];

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic drive_idle();
        lk_valid = 0; up_valid = 0;
    endtask

    task automatic drive_lk(input int tag, input int da, input int sa);
        lk_valid = 1; up_valid = 0;
        lk_tag = TW'(tag); lk_da_addr = AW'(da); lk_sa_addr = AW'(sa);
    endtask

    task automatic drive_up(input int addr, input int data);
        lk_valid = 0; up_valid = 1;
        up_addr = AW'(addr); up_data = DW'(data);
    endtask

    task automatic check_rsp(input string req, input int tag, input int da, input int sa,
                             input bit ha, input bit hb);
        ceq({req, " rsp_valid"}, 32'(rsp_valid), 1);
        ceq({req, " rsp_tag"}, 32'(rsp_tag), 32'(tag));
        ceq({req, " da_data"}, 32'(rsp_da_data), 32'(da));
        ceq({req, " sa_data"}, 32'(rsp_sa_data), 32'(sa));
        ceq({req, " da_hit"}, 32'(rsp_da_hit), 32'(ha));
        ceq({req, " sa_hit"}, 32'(rsp_sa_hit), 32'(hb));
    endtask

    task automatic test_reset();
        ceq("R1 lk_ready", 32'(lk_ready), 1);
        ceq("R1 up_ready", 32'(up_ready), 1);
        ceq("R1 rsp_valid", 32'(rsp_valid), 0);
        ceq("R1 cmd", 32'({a_v, b_v}), 0);
    endtask

    task automatic test_miss_lookup(input int tag, input int da, input int sa);
        @(negedge clk); drive_lk(tag, da, sa); #1;
        ceq("R2 read A", 32'({a_v, a_w, a_addr}), 32'({2'b10, AW'(da)}));
        ceq("R2 read B", 32'({b_v, b_w, b_addr}), 32'({2'b10, AW'(sa)}));
        for (int k = 1; k <= RD_LAT; k++) begin
            @(negedge clk); drive_idle(); #1;
            if (k == RD_LAT - 1) ceq("R2 early rsp", 32'(rsp_valid), 0);
        end
        check_rsp("R2", tag, init_val(da), init_val(sa), 0, 0);
    endtask

    // full group with a pending turnaround and a forwarded lookup
    task automatic test_full_group();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); drive_idle();
            case (k)
                0: drive_up(40, 16'hD000);
                1: drive_up(41, 16'hD001);
                2: drive_up(42, 16'hD002);
                3: drive_lk(5, 40, 51);
                4: drive_up(40, 16'hD003);
                11: drive_lk(6, 40, 41);
                13: drive_lk(7, 40, 42);
                default: ;
            endcase
            #1;
            case (k)
                0, 4: ceq("R3 up_ready open", 32'(up_ready), 1);
                3: begin
                    ceq("R9 no read A on hit", 32'(a_v), 0);
                    ceq("R2 read B on miss", 32'({b_v, b_w, b_addr}), 32'({2'b10, AW'(51)}));
                end
                5: begin
                    ceq("R3 up_ready full", 32'(up_ready), 0);
                    ceq("R12 lk_ready flush", 32'(lk_ready), 0);
                end
                6, 7: ceq("R6 no early write", 32'({a_v && a_w, b_v && b_w}), 0);
                8: begin
                    ceq("R4 first A", 32'({a_v, a_w, a_addr}), 32'({2'b11, AW'(40)}));
                    ceq("R4 first B", 32'({b_v, b_w, b_addr}), 32'({2'b11, AW'(41)}));
                    ceq("R12 lk_ready writing", 32'(lk_ready), 0);
                    check_rsp("R9", 5, 16'hD000, init_val(51), 1, 0);
                end
                9: begin
                    ceq("R4 second A", 32'({a_v, a_w, a_addr}), 32'({2'b11, AW'(42)}));
                    ceq("R4 second B", 32'({b_v, b_w, b_addr}), 32'({2'b11, AW'(40)}));
                end
                10: begin
                    ceq("R7 lk_ready after writes", 32'(lk_ready), 1);
                    ceq("R3 up_ready drain", 32'(up_ready), 0);
                end
                11: begin
                    ceq("R9 no reads on double hit", 32'({a_v, b_v}), 0);
                    ceq("R8 wdata A", 32'(a_wd), 32'h0000D000);
                    ceq("R8 wdata B", 32'(b_wd), 32'h0000D001);
                end
                12: begin
                    ceq("R8 wdata A2", 32'(a_wd), 32'h0000D002);
                    ceq("R8 wdata B2", 32'(b_wd), 32'h0000D003);
                end
                13: ceq("R11 read after commit", 32'({a_v, a_w, a_addr}), 32'({2'b10, AW'(40)}));
                14: ceq("R3 up_ready reopened", 32'(up_ready), 1);
                16: check_rsp("R10", 6, 16'hD003, 16'hD001, 1, 1);
                18: check_rsp("R11", 7, 16'hD003, 16'hD002, 0, 0);
                default: ;
            endcase
        end
    endtask

    task automatic test_timeout();
        for (int k = 0; k < 28; k++) begin
            @(negedge clk); drive_idle();
            case (k)
                0: drive_up(60, 16'h6000);
                1: drive_up(61, 16'h6001);
                2: drive_lk(9, 60, 61);
                default: ;
            endcase
            #1;
            case (k)
                2: ceq("R9 no reads", 32'({a_v, b_v}), 0);
                7: check_rsp("R9 timeout hit", 9, 16'h6000, 16'h6001, 1, 1);
                10: ceq("R5 partial waits", 32'(up_ready), 1);
                21: begin
                    ceq("R5 no write yet", 32'({a_v && a_w, b_v && b_w}), 0);
                    ceq("R12 lk_ready flush", 32'(lk_ready), 0);
                end
                22: begin
                    ceq("R5 write A", 32'({a_v, a_w, a_addr}), 32'({2'b11, AW'(60)}));
                    ceq("R5 write B", 32'({b_v, b_w, b_addr}), 32'({2'b11, AW'(61)}));
                end
                23: ceq("R7 lk_ready", 32'(lk_ready), 1);
                25: ceq("R8 wdata A", 32'(a_wd), 32'h00006000);
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        test_reset();
        test_miss_lookup(3, 5, 9);
        test_miss_lookup(12, 200, 201);
        repeat (6) @(negedge clk);
        test_full_group();
        repeat (6) @(negedge clk);
        test_timeout();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule